// File: doc/BRIEF.md
# HDLC Link Status Interrupt Register

This block keeps an eight-bit, read-only status word for a framed signalling channel and raises an interrupt request from it. A receive framer, a transmit framer and an address decoder deliver single-cycle event strobes. The receive side also gives one strobe per received byte. The link's loopback and back-off controllers deliver steady levels. Each latched bit has its own set and clear events: a byte-count delay after an opening flag, the closing flag or abort of a frame, a host read of the word, or a load of the receive or transmit control register.

The host samples `status_o` in the cycle that it raises `host_rd_i`. The bits that clear on a read fall at the following clock edge, so the host sees the value from before the clear. A set event in the same cycle as a read is kept. Three of the bits can drive `irq_o`, and each of them has its own enable bit in one of two mode words. The request is a level. It stays high while any enabled source bit stays latched.

Top module: `hdlc_link_status`

## Requirements
- R1: On reset, and in any cycle after which `idle_i` was high, latched bits 0, 1, 2, 6 and 7 are 0 and the byte delay is cancelled.
- R2: Bit 2 (frame in progress) sets at the first `rx_byte_i` strobe after `rx_open_i`. It clears on `rx_open_i`, `rx_close_i` or `rx_abort_i`, and a flag or abort in the same cycle as that byte wins. A host read or a control-register load leaves it unchanged.
- R3: With `addr_dec_en_i`=1, bit 0 (address seen) sets at the second `rx_byte_i` strobe after `rx_open_i`, but only if `addr_valid_i` is 1 in that cycle.
- R4: With `addr_dec_en_i`=0, bit 0 sets on an `rx_eoa_i` strobe, and the byte count does not set it.
- R5: Bit 1 (end of received frame) sets on `rx_close_i`.
- R6: Bits 0 and 1 clear after a cycle with `host_rd_i` or `rx_ctl_load_i` high.
- R7: Bit 3 follows `loop_local_i`, bit 4 follows `loop_line_i` and bit 5 is the inverse of `backoff_busy_i`, in the same cycle and with no latching.
- R8: Bit 6 sets on `tx_close_i` and bit 7 sets on `tx_abort_i`. Both clear after a cycle with `host_rd_i` or `tx_ctl_load_i` high.
- R9: A set event in the same cycle as a read or load that clears the bit leaves the bit set.
- R10: `irq_o` = (bit0 & `mode3_i[0]`) | (bit1 & `mode1_i[3]`) | (bit6 & `mode3_i[1]`). No other bit raises it.
- R11: Each `rx_open_i` restarts the byte count, so the one-byte and two-byte delays are counted from the latest opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idle_i | input | 1 | Idle mode, clears latched bits |
| rx_open_i | input | 1 | Opening flag received |
| rx_byte_i | input | 1 | One pulse per received byte |
| rx_close_i | input | 1 | Closing flag received |
| rx_abort_i | input | 1 | Abort received |
| addr_dec_en_i | input | 1 | Address recognition enabled |
| addr_valid_i | input | 1 | Decoded address matches |
| rx_eoa_i | input | 1 | End of address field (decode disabled) |
| rx_ctl_load_i | input | 1 | Receive control register loaded |
| tx_close_i | input | 1 | Closing flag transmitted |
| tx_abort_i | input | 1 | Abort transmitted |
| tx_ctl_load_i | input | 1 | Transmit control register loaded |
| host_rd_i | input | 1 | Host reads the status word |
| loop_local_i | input | 1 | Local loopback active |
| loop_line_i | input | 1 | Line-interface loopback active |
| backoff_busy_i | input | 1 | Back-off in operation |
| mode1_i | input | 8 | Mode word 1 (bit 3 enables bit 1) |
| mode3_i | input | 8 | Mode word 3 (bits 0, 1 enable bits 0, 6) |
| status_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt request level |

## Verification
The receive path is tried with a frame that has a valid address, with an invalid address, with address recognition off, and with an opening flag repeated partway through the address. These cases separate the one-byte and two-byte delays, the gating on address validity, the end-of-address path and the restart of the count. Reads and control-register loads are placed alone and in the same cycle as set events, which shows whether each clear reaches only its own bits and whether a set survives a simultaneous clear. Each interrupt enable is opened on its own, and the mask words are also set to all ones, to show that only the three allowed bits raise the request. A long stretch of sparse random strobes is then compared with the reference model on every cycle.

// File: rtl/hdlc_ls_pkg.sv
package hdlc_ls_pkg;
    localparam int STATUS_W = 8;

    typedef struct packed {
        logic va;
        logic eop;
        logic busy;
    } rx_flags_t;

    typedef struct packed {
        logic done;
        logic abrt;
    } tx_flags_t;
endpackage

// File: rtl/hdlc_ls_rx_track.sv
module hdlc_ls_rx_track
    import hdlc_ls_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int BUSY_BYTES = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_i,
    input  logic      open_i,
    input  logic      byte_i,
    input  logic      close_i,
    input  logic      abort_i,
    input  logic      dec_en_i,
    input  logic      addr_valid_i,
    input  logic      eoa_i,
    input  logic      ctl_load_i,
    input  logic      host_rd_i,
    output rx_flags_t flags_o
);
    localparam int CW = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
        rx_flags_t     f;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic flag_ev, busy_hit, addr_hit;

    always_comb begin
        s_d      = s_q;
        flag_ev  = open_i | close_i | abort_i;
        busy_hit = byte_i && s_q.active && !flag_ev && (s_q.cnt == CW'(BUSY_BYTES - 1));
        addr_hit = byte_i && s_q.active && !flag_ev && (s_q.cnt == CW'(ADDR_BYTES - 1));
        if (idle_i) begin
            s_d = '0;
        end else begin
            if (open_i) begin
                s_d.cnt    = '0;
                s_d.active = 1'b1;
            end else if (close_i || abort_i) begin
                s_d.cnt    = '0;
                s_d.active = 1'b0;
            end else if (byte_i && s_q.active && (s_q.cnt < CW'(ADDR_BYTES))) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
            if (host_rd_i || ctl_load_i) begin
                s_d.f.va  = 1'b0;
                s_d.f.eop = 1'b0;
            end
            if (flag_ev)       s_d.f.busy = 1'b0;
            else if (busy_hit) s_d.f.busy = 1'b1;
            if ((dec_en_i && addr_hit && addr_valid_i) || (!dec_en_i && eoa_i))
                s_d.f.va = 1'b1;
            if (close_i) s_d.f.eop = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.f;

    a_r2_busy_drops_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (open_i || close_i || abort_i) |=> !flags_o.busy);
    a_r2_busy_ignores_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && flags_o.busy && !(open_i || close_i || abort_i || idle_i)) |=> flags_o.busy);
    a_r4_eoa_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_en_i && eoa_i && !idle_i) |=> flags_o.va);
    a_r5_close_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && !idle_i) |=> flags_o.eop);
    a_r6_eop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd_i || ctl_load_i) && !close_i) |=> !flags_o.eop);
    a_r9_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && close_i && !idle_i) |=> flags_o.eop);
    a_r1_idle_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (flags_o == '0));
endmodule

// File: rtl/hdlc_ls_tx_track.sv
module hdlc_ls_tx_track
    import hdlc_ls_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle_i,
    input  logic      close_i,
    input  logic      abort_i,
    input  logic      ctl_load_i,
    input  logic      host_rd_i,
    output tx_flags_t flags_o
);
    tx_flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (idle_i) begin
            f_d = '0;
        end else begin
            if (host_rd_i || ctl_load_i) f_d = '0;
            if (close_i) f_d.done = 1'b1;
            if (abort_i) f_d.abrt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags_o = f_q;

    a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && !idle_i) |=> flags_o.done);
    a_r8_abort_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !idle_i) |=> flags_o.abrt);
    a_r8_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd_i || ctl_load_i) && !close_i && !abort_i) |=> (flags_o == '0));
    a_r1_idle_clears_tx: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (flags_o == '0));
endmodule

// File: rtl/hdlc_ls_irq.sv
module hdlc_ls_irq
    import hdlc_ls_pkg::*;
#(
    parameter int MODE_W  = 8,
    parameter int EN_VA   = 0,
    parameter int EN_EOP  = 3,
    parameter int EN_DONE = 1
) (
    input  logic [STATUS_W-1:0] status_i,
    input  logic [MODE_W-1:0]   mode1_i,
    input  logic [MODE_W-1:0]   mode3_i,
    output logic                irq_o
);
    logic [2:0] src;

    always_comb begin
        src[0] = status_i[0] & mode3_i[EN_VA];
        src[1] = status_i[1] & mode1_i[EN_EOP];
        src[2] = status_i[6] & mode3_i[EN_DONE];
        irq_o  = |src;
    end
endmodule

// File: rtl/hdlc_link_status.sv
module hdlc_link_status
    import hdlc_ls_pkg::*;
#(
    parameter int ADDR_BYTES = 2,
    parameter int BUSY_BYTES = 1,
    parameter int MODE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle_i,
    input  logic              rx_open_i,
    input  logic              rx_byte_i,
    input  logic              rx_close_i,
    input  logic              rx_abort_i,
    input  logic              addr_dec_en_i,
    input  logic              addr_valid_i,
    input  logic              rx_eoa_i,
    input  logic              rx_ctl_load_i,
    input  logic              tx_close_i,
    input  logic              tx_abort_i,
    input  logic              tx_ctl_load_i,
    input  logic              host_rd_i,
    input  logic              loop_local_i,
    input  logic              loop_line_i,
    input  logic              backoff_busy_i,
    input  logic [MODE_W-1:0] mode1_i,
    input  logic [MODE_W-1:0] mode3_i,
    output logic [7:0]        status_o,
    output logic              irq_o
);
    rx_flags_t rx_f;
    tx_flags_t tx_f;

    hdlc_ls_rx_track #(.ADDR_BYTES(ADDR_BYTES), .BUSY_BYTES(BUSY_BYTES)) i_rx (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .open_i(rx_open_i), .byte_i(rx_byte_i),
        .close_i(rx_close_i), .abort_i(rx_abort_i), .dec_en_i(addr_dec_en_i),
        .addr_valid_i(addr_valid_i), .eoa_i(rx_eoa_i), .ctl_load_i(rx_ctl_load_i),
        .host_rd_i(host_rd_i), .flags_o(rx_f)
    );

    hdlc_ls_tx_track i_tx (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .close_i(tx_close_i), .abort_i(tx_abort_i),
        .ctl_load_i(tx_ctl_load_i), .host_rd_i(host_rd_i), .flags_o(tx_f)
    );

    always_comb begin
        status_o = {tx_f.abrt, tx_f.done, ~backoff_busy_i, loop_line_i, loop_local_i,
                    rx_f.busy, rx_f.eop, rx_f.va};
    end

    hdlc_ls_irq #(.MODE_W(MODE_W)) i_irq (
        .status_i(status_o), .mode1_i(mode1_i), .mode3_i(mode3_i), .irq_o(irq_o)
    );

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode3_i[0] && !mode3_i[1] && !mode1_i[3]) |-> !irq_o);
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rx_f.va || rx_f.eop || tx_f.done));
endmodule

// File: tb/test_hdlc_link_status.sv
module test_hdlc_link_status;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic idle, ropen, rbyte, rclose, rabort, dec_en, avalid, eoa, rload;
    logic tclose, tabort, tload, rd, lloc, lline, boff;
    logic [7:0] mode1, mode3, status;
    logic irq;
    int checks = 0, errors = 0;
    int m_cnt;
    bit m_act;
    bit [7:0] m_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_link_status i_hdlc_link_status (
        .clk(clk), .rst_n(rst_n), .idle_i(idle), .rx_open_i(ropen), .rx_byte_i(rbyte),
        .rx_close_i(rclose), .rx_abort_i(rabort), .addr_dec_en_i(dec_en), .addr_valid_i(avalid),
        .rx_eoa_i(eoa), .rx_ctl_load_i(rload), .tx_close_i(tclose), .tx_abort_i(tabort),
        .tx_ctl_load_i(tload), .host_rd_i(rd), .loop_local_i(lloc), .loop_line_i(lline),
        .backoff_busy_i(boff), .mode1_i(mode1), .mode3_i(mode3), .status_o(status), .irq_o(irq)
    );

    // Behavioural reference model, written from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || idle) begin
            m_bits <= 0; m_cnt <= 0; m_act <= 0;
        end else begin
            bit [7:0] b;
            bit fl;
            b = m_bits;
            fl = ropen || rclose || rabort;
            if (rd || rload) begin b[0] = 0; b[1] = 0; end
            if (rd || tload) begin b[6] = 0; b[7] = 0; end
            if (fl) b[2] = 0;
            else if (rbyte && m_act && m_cnt == 0) b[2] = 1;
            if (dec_en && rbyte && m_act && !fl && m_cnt == 1 && avalid) b[0] = 1;
            if (!dec_en && eoa) b[0] = 1;
            if (rclose) b[1] = 1;
            if (tclose) b[6] = 1;
            if (tabort) b[7] = 1;
            m_bits <= b;
            if (ropen) begin m_cnt <= 0; m_act <= 1; end
            else if (rclose || rabort) begin m_cnt <= 0; m_act <= 0; end
            else if (rbyte && m_act && m_cnt < 2) m_cnt <= m_cnt + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        bit [7:0] e;
        bit ei;
        e = m_bits;
        e[3] = lloc; e[4] = lline; e[5] = !boff;
        ei = (e[0] && mode3[0]) || (e[1] && mode1[3]) || (e[6] && mode3[1]);
        chk("R3/R4 bit0", status[0], e[0]);
        chk("R5 bit1", status[1], e[1]);
        chk("R2 bit2", status[2], e[2]);
        chk("R7 live bits", status[5:3], e[5:3]);
        chk("R8 tx bits", status[7:6], e[7:6]);
        chk("R10 irq", irq, ei);
    endtask

    task automatic clr();
        idle = 0; ropen = 0; rbyte = 0; rclose = 0; rabort = 0; eoa = 0;
        rload = 0; tclose = 0; tabort = 0; tload = 0; rd = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        clr();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clr();
        dec_en = 1; avalid = 1; lloc = 0; lline = 0; boff = 1; mode1 = 0; mode3 = 0;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk("R1 reset status", status, 8'h00);
        rst_n = 1;
        tick();
        // R3 valid address, R2 busy after one byte
        ropen = 1; tick();
        rbyte = 1; tick();
        chk("R2 busy after first byte", status[2], 1);
        chk("R3 no va after one byte", status[0], 0);
        mode3 = 8'h01;
        rbyte = 1; tick();
        chk("R3 va after second byte", status[0], 1);
        chk("R10 irq via mode3 bit0", irq, 1);
        // R6 read clears va, busy stays (R2)
        rd = 1; tick();
        chk("R6 read clears va", status[0], 0);
        chk("R2 busy survives read", status[2], 1);
        chk("R10 irq falls", irq, 0);
        // R5 close
        mode1 = 8'h08;
        rclose = 1; tick();
        chk("R5 eop set", status[1], 1);
        chk("R2 busy clears on close", status[2], 0);
        chk("R10 irq via mode1 bit3", irq, 1);
        rload = 1; tick();
        chk("R6 rx load clears eop", status[1], 0);
        // R3 invalid address
        avalid = 0;
        ropen = 1; tick(); rbyte = 1; tick(); rbyte = 1; tick();
        chk("R3 invalid address keeps va low", status[0], 0);
        rabort = 1; tick();
        chk("R2 abort clears busy", status[2], 0);
        // R4 decode disabled
        dec_en = 0; avalid = 1;
        ropen = 1; tick(); rbyte = 1; tick(); rbyte = 1; tick();
        chk("R4 byte count ignored when decode off", status[0], 0);
        eoa = 1; tick();
        chk("R4 eoa sets va", status[0], 1);
        // R9 set beats read
        rd = 1; rclose = 1; tick();
        chk("R9 eop kept against read", status[1], 1);
        chk("R9 va cleared by same read", status[0], 0);
        rd = 1; tick();
        // R11 restart
        dec_en = 1;
        ropen = 1; tick(); rbyte = 1; tick(); ropen = 1; tick();
        chk("R11 busy cleared by reopen", status[2], 0);
        rbyte = 1; tick();
        chk("R11 no va one byte after reopen", status[0], 0);
        rbyte = 1; tick();
        chk("R11 va two bytes after reopen", status[0], 1);
        rd = 1; tick();
        // R8 tx
        mode3 = 8'h02;
        tclose = 1; tick();
        chk("R8 tx done", status[6], 1);
        chk("R10 irq via mode3 bit1", irq, 1);
        tabort = 1; tick();
        chk("R8 tx abort", status[7], 1);
        rload = 1; tick();
        chk("R8 rx load leaves tx bits", status[7:6], 2'b11);
        tload = 1; tick();
        chk("R8 tx load clears", status[7:6], 2'b00);
        tabort = 1; tick(); mode3 = 8'hFC; mode1 = 8'hF7;
        tick();
        chk("R10 abort bit never raises irq", irq, 0);
        rd = 1; tick();
        chk("R8 read clears abort", status[7], 0);
        // R7 live levels
        lloc = 1; lline = 0; boff = 0; #1;
        chk("R7 live same cycle", status[5:3], 3'b101);
        lloc = 0; lline = 1; boff = 1; #1;
        chk("R7 live same cycle b", status[5:3], 3'b010);
        // R1 idle
        ropen = 1; tick(); rbyte = 1; rclose = 0; tick(); rclose = 1; tclose = 1; tick();
        idle = 1; tick();
        chk("R1 idle clears latched", {status[7:6], status[2:0]}, 0);
        rbyte = 1; tick();
        chk("R1 idle cancels count", status[2], 0);
        // random
        mode1 = 8'hFF; mode3 = 8'hFF;
        for (int i = 0; i < 3000; i++) begin
            ropen = ($urandom % 12) == 0; rbyte = ($urandom % 2) == 0;
            rclose = ($urandom % 14) == 0; rabort = ($urandom % 30) == 0;
            eoa = ($urandom % 10) == 0; rload = ($urandom % 16) == 0;
            tclose = ($urandom % 10) == 0; tabort = ($urandom % 15) == 0;
            tload = ($urandom % 16) == 0; rd = ($urandom % 6) == 0;
            idle = ($urandom % 80) == 0; dec_en = ($urandom % 4) != 0;
            avalid = ($urandom % 3) != 0; lloc = $urandom; lline = $urandom; boff = $urandom;
            if (i % 100 == 0) begin mode1 = $urandom; mode3 = $urandom; end
            tick();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule